// File: doc/BRIEF.md
# Discoverable-Parameter Table Read Responder

This block is the device-side responder for the serial-flash discoverable-parameter read. A host selects the device with `cs_i`, then shifts in a command as a stream of bytes: an opcode, a 24-bit big-endian start address, a dummy byte and possibly more filler. It then asks for read bytes one at a time. The responder keeps an 88-byte fixed parameter table and answers each read request with one table byte, one cycle after the request.

The byte read first depends on how many bytes the host wrote. If the dummy byte is missing, the first read byte takes its place. Each written byte past the dummy moves the start of the table data forward by one, because the device is already shifting data out during those bytes. The start offset wraps modulo the table size. The responder answers only when its configuration input says that discoverable parameters are supported. In every other case it returns the idle byte 0xFF.

Top module: `sfdp_responder`

## Requirements
- R1: While `cs_i` is low the write count is cleared. Each cycle in which `cs_i` and `rd_req_i` are both high yields `rd_vld_o`=1 on the next cycle, and no other cycle yields it. Out of reset, `rd_vld_o`=0 and `rd_byte_o`=0xFF.
- R2: Opcode 0x5A, with `cfg_en_i`=1, then address bytes A[23:16], A[15:8], A[7:0] and exactly one more byte (five written in all): the first read returns table byte (A mod 88).
- R3: With fewer than four bytes written in the transaction, every read returns 0xFF.
- R4: With exactly four bytes written, the first read returns 0xFF and the second read returns table byte (A mod 88).
- R5: With N > 5 bytes written, the first read returns table byte ((A + N - 5) mod 88).
- R6: A start offset at or above 88 wraps to the offset modulo 88. This includes offsets pushed past the end by extra written bytes.
- R7: Successive reads in one transaction return successive table bytes. Only bytes below offset 88 are defined.
- R8: With `cfg_en_i`=0, or with any opcode other than 0x5A, every read returns 0xFF.
- R9: The table starts with 0x53 0x46 0x44 0x50 ("SFDP"), then 0x00 0x01 0x01. Unused holes, such as offsets 0x18 to 0x1B, read 0xFF. Offset 0x57 holds 0x5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Device supports discoverable parameters |
| cs_i | input | 1 | Transaction select, high while a command is in progress |
| wr_vld_i | input | 1 | A host byte is present on `wr_byte_i` |
| wr_byte_i | input | 8 | Host-written byte |
| rd_req_i | input | 1 | Request one read byte |
| rd_vld_o | output | 1 | Read byte valid, one cycle after the request |
| rd_byte_o | output | 8 | Read byte |

## Verification
The bench varies the written byte count around the dummy position: three, four, five and seven bytes. A design that miscounted would return the table shifted by one or more bytes, or would give table data where the dummy 0xFF belongs. It uses start addresses above 88, including a large 24-bit value, and extra filler bytes that push an offset of 87 past the end. A design that clamped the offset or wrapped at a power of two would return the wrong byte. Disabled and foreign-opcode transactions must return only 0xFF, and the read that lands on the last table byte guards against an off-by-one at the end of the table.

// File: rtl/sfdp_pkg.sv
package sfdp_pkg;
  localparam logic [7:0] SFDP_OPCODE = 8'h5A;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
  localparam int         HDR_WRITES  = 4;  // opcode + 3 address bytes
endpackage

// File: rtl/sfdp_rom.sv
module sfdp_rom
  import sfdp_pkg::*;
#(
  parameter int TABLE_BYTES = 88,
  parameter int PTR_W       = $clog2(TABLE_BYTES + 1)
) (
  input  logic [PTR_W-1:0] idx_i,
  output logic [7:0]       data_o
);
  always_comb begin
    data_o = IDLE_BYTE;
    if (int'(idx_i) < TABLE_BYTES) begin
      case (int'(idx_i))
        'h00: data_o = 8'h53;
        'h01: data_o = 8'h46;
        'h02: data_o = 8'h44;
        'h03: data_o = 8'h50;
        'h04: data_o = 8'h00;
        'h05: data_o = 8'h01;
        'h06: data_o = 8'h01;
        'h08: data_o = 8'h00;
        'h09: data_o = 8'h00;
        'h0A: data_o = 8'h01;
        'h0B: data_o = 8'h09;
        'h0C: data_o = 8'h1C;
        'h0D: data_o = 8'h00;
        'h0E: data_o = 8'h00;
        'h10: data_o = 8'hC2;
        'h11: data_o = 8'h00;
        'h12: data_o = 8'h01;
        'h13: data_o = 8'h04;
        'h14: data_o = 8'h48;
        'h15: data_o = 8'h00;
        'h16: data_o = 8'h00;
        'h1C: data_o = 8'hE5;
        'h1D: data_o = 8'h20;
        'h1E: data_o = 8'hC9;
        'h23: data_o = 8'h03;
        'h24: data_o = 8'h00;
        'h26: data_o = 8'h08;
        'h27: data_o = 8'h6B;
        'h28: data_o = 8'h08;
        'h29: data_o = 8'h3B;
        'h2A: data_o = 8'h00;
        'h38: data_o = 8'h0C;
        'h39: data_o = 8'h20;
        'h3A: data_o = 8'h0F;
        'h3B: data_o = 8'h52;
        'h48: data_o = 8'h00;
        'h49: data_o = 8'h36;
        'h4A: data_o = 8'h00;
        'h4B: data_o = 8'h27;
        'h57: data_o = 8'h5A;
        default: data_o = IDLE_BYTE;
      endcase
    end
  end
endmodule

// File: rtl/sfdp_cmd_track.sv
module sfdp_cmd_track
  import sfdp_pkg::*;
#(
  parameter int TABLE_BYTES = 88,
  parameter int CNT_W       = 8,
  parameter int PTR_W       = $clog2(TABLE_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             wr_vld_i,
  input  logic [7:0]       wr_byte_i,
  output logic [7:0]       opcode_o,
  output logic [CNT_W-1:0] wcnt_o,
  output logic [PTR_W-1:0] start_off_o
);
  localparam int FOLD_W = PTR_W + 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_WRITES);
  localparam logic [PTR_W-1:0] OFF_LAST = PTR_W'(TABLE_BYTES - 1);

  logic [7:0]       op_q;
  logic [CNT_W-1:0] wcnt_q;
  logic [PTR_W-1:0] res_q;
  logic [FOLD_W-1:0] fold_w;
  logic [PTR_W-1:0] fold_next;

  // Residue of the address mod table size, folded in one byte at a time
  assign fold_w    = {res_q, wr_byte_i};
  assign fold_next = PTR_W'(fold_w % FOLD_W'(TABLE_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      wcnt_q <= '0;
      res_q  <= '0;
    end else if (!cs_i) begin
      op_q   <= '0;
      wcnt_q <= '0;
      res_q  <= '0;
    end else if (wr_vld_i) begin
      if (wcnt_q != CNT_MAX) wcnt_q <= wcnt_q + 1'b1;
      if (wcnt_q == '0) begin
        op_q <= wr_byte_i;
      end else if (wcnt_q < CNT_HDR) begin
        res_q <= fold_next;
      end else if (wcnt_q > CNT_HDR) begin
        // bytes beyond the dummy advance the start offset
        res_q <= (res_q == OFF_LAST) ? '0 : res_q + 1'b1;
      end
    end
  end

  assign opcode_o    = op_q;
  assign wcnt_o      = wcnt_q;
  assign start_off_o = res_q;

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> (wcnt_q == '0)); // R1
  AST_OFF_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(res_q) < TABLE_BYTES); // R6
endmodule

// File: rtl/sfdp_rd_ctrl.sv
module sfdp_rd_ctrl
  import sfdp_pkg::*;
#(
  parameter int TABLE_BYTES = 88,
  parameter int CNT_W       = 8,
  parameter int PTR_W       = $clog2(TABLE_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_en_i,
  input  logic             cs_i,
  input  logic             rd_req_i,
  input  logic [7:0]       opcode_i,
  input  logic [CNT_W-1:0] wcnt_i,
  input  logic [PTR_W-1:0] start_off_i,
  input  logic [7:0]       rom_byte_i,
  output logic [PTR_W-1:0] rom_idx_o,
  output logic             rd_vld_o,
  output logic [7:0]       rd_byte_o
);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_WRITES);
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(TABLE_BYTES);

  logic             started_q, open_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] cur_ptr;
  logic             open_now, skip_now, in_tab, take;

  assign take     = cs_i && rd_req_i;
  assign cur_ptr  = started_q ? ptr_q : start_off_i;
  assign open_now = started_q ? open_q
                  : (cfg_en_i && (opcode_i == SFDP_OPCODE) && (wcnt_i >= CNT_HDR));
  // missing dummy: first read stands in for it
  assign skip_now = !started_q && (wcnt_i == CNT_HDR);
  assign in_tab   = cur_ptr < PTR_END;
  assign rom_idx_o = cur_ptr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      open_q    <= 1'b0;
      ptr_q     <= '0;
      rd_vld_o  <= 1'b0;
      rd_byte_o <= IDLE_BYTE;
    end else begin
      rd_vld_o  <= take;
      rd_byte_o <= IDLE_BYTE;
      if (!cs_i) begin
        started_q <= 1'b0;
        open_q    <= 1'b0;
        ptr_q     <= '0;
      end else if (rd_req_i) begin
        started_q <= 1'b1;
        open_q    <= open_now;
        ptr_q     <= (skip_now || !in_tab) ? cur_ptr : cur_ptr + 1'b1;
        if (open_now && !skip_now && in_tab) rd_byte_o <= rom_byte_i;
      end
    end
  end

  AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_req_i) |=> rd_vld_o); // R1
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_req_i) |=> !rd_vld_o); // R1
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_req_i && !started_q && !cfg_en_i) |=> (rd_byte_o == IDLE_BYTE)); // R8
  AST_DUMMY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_req_i && !started_q && (wcnt_i == CNT_HDR)) |=> (rd_byte_o == IDLE_BYTE)); // R4
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_req_i && started_q && (ptr_q < PTR_END)) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R7
endmodule

// File: rtl/sfdp_responder.sv
module sfdp_responder
  import sfdp_pkg::*;
#(
  parameter int TABLE_BYTES = 88,
  parameter int CNT_W       = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_en_i,
  input  logic       cs_i,
  input  logic       wr_vld_i,
  input  logic [7:0] wr_byte_i,
  input  logic       rd_req_i,
  output logic       rd_vld_o,
  output logic [7:0] rd_byte_o
);
  localparam int PTR_W = $clog2(TABLE_BYTES + 1);

  logic [7:0]       opcode;
  logic [CNT_W-1:0] wcnt;
  logic [PTR_W-1:0] start_off;
  logic [PTR_W-1:0] rom_idx;
  logic [7:0]       rom_byte;

  sfdp_cmd_track #(.TABLE_BYTES(TABLE_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .wr_vld_i    (wr_vld_i),
    .wr_byte_i   (wr_byte_i),
    .opcode_o    (opcode),
    .wcnt_o      (wcnt),
    .start_off_o (start_off)
  );

  sfdp_rom #(.TABLE_BYTES(TABLE_BYTES), .PTR_W(PTR_W)) u_rom (
    .idx_i  (rom_idx),
    .data_o (rom_byte)
  );

  sfdp_rd_ctrl #(.TABLE_BYTES(TABLE_BYTES), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_en_i    (cfg_en_i),
    .cs_i        (cs_i),
    .rd_req_i    (rd_req_i),
    .opcode_i    (opcode),
    .wcnt_i      (wcnt),
    .start_off_i (start_off),
    .rom_byte_i  (rom_byte),
    .rom_idx_o   (rom_idx),
    .rd_vld_o    (rd_vld_o),
    .rd_byte_o   (rd_byte_o)
  );
endmodule

// File: tb/sfdp_responder_test.sv
`timescale 1ns/1ps
module sfdp_responder_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_en_i = 1'b1;
  logic       cs_i = 1'b0;
  logic       wr_vld_i = 1'b0;
  logic [7:0] wr_byte_i = 8'h00;
  logic       rd_req_i = 1'b0;
  logic       rd_vld_o;
  logic [7:0] rd_byte_o;

  int tests_run = 0;
  int tests_failed = 0;

  always #2.5 clk_i = ~clk_i;

  sfdp_responder uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_en_i(cfg_en_i), .cs_i(cs_i),
    .wr_vld_i(wr_vld_i), .wr_byte_i(wr_byte_i), .rd_req_i(rd_req_i),
    .rd_vld_o(rd_vld_o), .rd_byte_o(rd_byte_o)
  );

  function automatic logic [7:0] tbl(input int i);
    case (i)
      'h00: return 8'h53; 'h01: return 8'h46; 'h02: return 8'h44; 'h03: return 8'h50;
      'h04: return 8'h00; 'h05: return 8'h01; 'h06: return 8'h01;
      'h08: return 8'h00; 'h09: return 8'h00; 'h0A: return 8'h01; 'h0B: return 8'h09;
      'h0C: return 8'h1C; 'h0D: return 8'h00; 'h0E: return 8'h00;
      'h10: return 8'hC2; 'h11: return 8'h00; 'h12: return 8'h01; 'h13: return 8'h04;
      'h14: return 8'h48; 'h15: return 8'h00; 'h16: return 8'h00;
      'h1C: return 8'hE5; 'h1D: return 8'h20; 'h1E: return 8'hC9;
      'h23: return 8'h03; 'h24: return 8'h00; 'h26: return 8'h08; 'h27: return 8'h6B;
      'h28: return 8'h08; 'h29: return 8'h3B; 'h2A: return 8'h00;
      'h38: return 8'h0C; 'h39: return 8'h20; 'h3A: return 8'h0F; 'h3B: return 8'h52;
      'h48: return 8'h00; 'h49: return 8'h36; 'h4A: return 8'h00; 'h4B: return 8'h27;
      'h57: return 8'h5A;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // One transaction: nwr bytes written, nrd bytes read, checked against the model
  task automatic txn(input string req, input logic [7:0] op, input int addr,
                     input int nwr, input int nrd, input logic en);
    logic open_t, skip_t;
    int off;
    cfg_en_i = en;
    open_t = en && (op == 8'h5A) && (nwr >= 4);
    skip_t = (nwr == 4);
    off = (addr + ((nwr > 5) ? nwr - 5 : 0)) % 88;
    @(negedge clk_i);
    cs_i = 1'b1;
    for (int k = 0; k < nwr; k++) begin
      wr_vld_i = 1'b1;
      case (k)
        0: wr_byte_i = op;
        1: wr_byte_i = 8'((addr >> 16) & 'hFF);
        2: wr_byte_i = 8'((addr >> 8) & 'hFF);
        3: wr_byte_i = 8'(addr & 'hFF);
        default: wr_byte_i = 8'hA5;
      endcase
      @(negedge clk_i);
    end
    wr_vld_i = 1'b0;
    for (int i = 0; i < nrd; i++) begin
      int idx;
      logic [7:0] exp;
      rd_req_i = 1'b1;
      @(negedge clk_i);
      if (i == 0) check({req, " vld"}, {7'd0, rd_vld_o}, 8'h01);
      idx = off + i - (skip_t ? 1 : 0);
      if (!open_t || (skip_t && i == 0)) exp = 8'hFF;
      else exp = tbl(idx);
      if (!open_t || idx < 88) check(req, rd_byte_o, exp);
    end
    rd_req_i = 1'b0;
    cs_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    check("R1 reset vld", {7'd0, rd_vld_o}, 8'h00);
    check("R1 reset byte", rd_byte_o, 8'hFF);
  endtask

  task automatic t_idle();
    @(negedge clk_i);
    cs_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 no request no vld", {7'd0, rd_vld_o}, 8'h00);
    cs_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_idle();
    txn("R2 R9 R7 signature", 8'h5A, 'h000000, 5, 8, 1'b1);
    txn("R9 holes", 8'h5A, 'h000018, 5, 5, 1'b1);
    txn("R2 last byte", 8'h5A, 'h000057, 5, 1, 1'b1);
    txn("R7 mid table", 8'h5A, 'h000026, 5, 6, 1'b1);
    txn("R4 missing dummy", 8'h5A, 'h000010, 4, 4, 1'b1);
    txn("R3 short command", 8'h5A, 'h000000, 3, 3, 1'b1);
    txn("R3 opcode only", 8'h5A, 'h000000, 1, 2, 1'b1);
    txn("R5 extra writes", 8'h5A, 'h000000, 7, 4, 1'b1);
    txn("R6 wrap at size", 8'h5A, 'h000058, 5, 3, 1'b1);
    txn("R6 wrap large", 8'h5A, 'h123456, 5, 3, 1'b1);
    txn("R6 R5 pushed past end", 8'h5A, 'h000057, 6, 2, 1'b1);
    txn("R5 many extra", 8'h5A, 'h000002, 15, 3, 1'b1);
    txn("R8 disabled", 8'h5A, 'h000000, 5, 3, 1'b0);
    txn("R8 other opcode", 8'h03, 'h000000, 5, 3, 1'b1);
    txn("R1 back to back", 8'h5A, 'h000004, 5, 3, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule